// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the integer execute stage of a 32-bit load/store core. Each cycle it takes two register operands (`op_a` in the source-register role, `op_b` in the target-register role), a 5-bit shift count from the instruction, a 6-bit function code and a 16-bit immediate. A select input decides whether the second operand comes from the register or from the immediate. The block computes one result word, an overflow indication for the trapping arithmetic forms, and an illegal-operation indication.

Both outputs are registered, so the result of an operation appears one clock after its inputs are applied. The unit covers addition and subtraction, the four bitwise operations, signed and unsigned set-on-less-than, fixed and variable shifts, and the load-upper-immediate operation. The block only raises the overflow and illegal flags. Trap handling, the register file, multiply/divide and memory access belong to other blocks.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst_n` is low, `result`, `ovf` and `illegal` are all zero. After reset, the outputs for the inputs sampled at a rising clock edge appear just after that edge and hold for one cycle.
- R2: With `imm_sel`=0, `func` 100000 (trapping add) and 100001 (plain add) give `op_a + op_b`. `func` 100010 (trapping subtract) and 100011 (plain subtract) give `op_a - op_b`. All four wrap modulo 2^32.
- R3: `ovf` is 1 only for the trapping forms (register 100000 and 100010, immediate 100000) and only when the signed result overflows. The plain forms and every other operation leave `ovf` at 0.
- R4: With `imm_sel`=0, `func` 100100, 100101 and 100110 give the bitwise AND, OR and XOR of `op_a` and `op_b`. `func` 100111 gives the inverse of their bitwise OR.
- R5: `func` 101010 sets the result to 1 when `op_a` is less than the second operand as signed numbers, and to 0 otherwise. `func` 101011 does the same comparison as unsigned numbers.
- R6: With `imm_sel`=0, `func` 000000, 000010 and 000011 shift `op_b` by `shamt`: left, right filling zeros, and right filling copies of bit 31, respectively.
- R7: With `imm_sel`=0, `func` 000100, 000110 and 000111 shift `op_b` left, right logically and right arithmetically by `op_a[4:0]`. Bits 31..5 of `op_a` and the `shamt` input have no effect on these operations.
- R8: A right arithmetic shift replicates bit 31 of `op_b` into every vacated position, and a right logical shift fills them with zeros, for counts from 0 up to 31.
- R9: With `imm_sel`=1, the immediate replaces `op_b`. `func` 100000, 100001, 101010 and 101011 sign-extend it (bit 15 into bits 31..16). `func` 100100, 100101 and 100110 zero-extend it. The unsigned compare (101011) uses the sign-extended value.
- R10: With `imm_sel`=1 and `func` 001111, the result is `imm` in bits 31..16 with bits 15..0 cleared, and `ovf` is 0.
- R11: Any other combination gives a zero result, `illegal`=1 and `ovf`=0. This covers every register-mode code not listed, 001111 in register mode, and in immediate mode every code except the seven above and 001111. For every legal combination, `illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | First operand (source register); low 5 bits give the variable shift count |
| op_b | input | 32 | Second operand (target register); the value that shifts move |
| shamt | input | 5 | Fixed shift count from the instruction |
| func | input | 6 | Function code selecting the operation |
| imm_sel | input | 1 | 1 = second operand comes from `imm` |
| imm | input | 16 | Immediate field |
| result | output | 32 | Registered result word |
| ovf | output | 1 | Registered signed-overflow flag for trapping add/subtract |
| illegal | output | 1 | Registered unsupported-operation flag |

## Verification
Addition and subtraction run at the two signed limits, so the trapping and plain forms separate on the overflow flag while producing the same wrapped sum. The comparisons use a negative value against a positive one, which tells the signed comparison from the unsigned one. Shifts run on a value with bit 31 set and on one with bit 31 clear at counts 0, 4 and 31, which exposes a wrong fill or a wrong direction. For the variable shifts, garbage is placed in the upper bits of `op_a` and in `shamt`, so that a wrong count source shows up. Immediates with bit 15 set tell sign extension from zero extension. A stream of pseudo-random operations then compares every code in both modes against an independent model.

// File: rtl/iu_pkg.sv
package iu_pkg;

    typedef enum logic [5:0] {
        FN_SLL   = 6'b000000,
        FN_SRL   = 6'b000010,
        FN_SRA   = 6'b000011,
        FN_SLLV  = 6'b000100,
        FN_SRLV  = 6'b000110,
        FN_SRAV  = 6'b000111,
        FN_LUI   = 6'b001111,
        FN_ADD   = 6'b100000,
        FN_ADDU  = 6'b100001,
        FN_SUB   = 6'b100010,
        FN_SUBU  = 6'b100011,
        FN_AND   = 6'b100100,
        FN_OR    = 6'b100101,
        FN_XOR   = 6'b100110,
        FN_NOR   = 6'b100111,
        FN_SLT   = 6'b101010,
        FN_SLTU  = 6'b101011
    } func_e;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
        K_SLT, K_SLTU, K_SHIFT, K_LUI, K_BAD
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  trap;
        logic  ext_sign;
        logic  var_shift;
        logic  sh_left;
        logic  sh_arith;
    } decode_t;

endpackage

// File: rtl/iu_operand_sel.sv
module iu_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = 5
) (
    input  logic [DATA_W-1:0] rt_val,
    input  logic [SH_W-1:0]   rs_low,
    input  logic [SH_W-1:0]   shamt,
    input  logic [IMM_W-1:0]  imm,
    input  logic              imm_sel,
    input  logic              ext_sign,
    input  logic              var_shift,
    output logic [DATA_W-1:0] b_op,
    output logic [SH_W-1:0]   sh_amt,
    output logic [DATA_W-1:0] upper_val
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        imm_ext   = {{PAD_W{ext_sign & imm[IMM_W-1]}}, imm};
        b_op      = imm_sel ? imm_ext : rt_val;
        sh_amt    = var_shift ? rs_low : shamt;
        upper_val = {imm, {PAD_W{1'b0}}};
    end

endmodule

// File: rtl/iu_shifter.sv
module iu_shifter #(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amt,
    input  logic              left,
    input  logic              arith,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stage [0:SH_W];
    logic              fill;

    assign fill     = arith & din[DATA_W-1];
    assign stage[0] = din;

    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        localparam int STEP = 1 << i;
        logic [DATA_W-1:0] moved;
        always_comb begin
            if (left)
                moved = {stage[i][DATA_W-1-STEP:0], {STEP{1'b0}}};
            else
                moved = {{STEP{fill}}, stage[i][DATA_W-1:STEP]};
        end
        assign stage[i+1] = amt[i] ? moved : stage[i];
    end

    assign dout = stage[SH_W];

endmodule

// File: rtl/iu_addsub.sv
module iu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf_raw,
    output logic              lt_s,
    output logic              lt_u
);
    logic [DATA_W-1:0] b_eff;

    always_comb begin
        b_eff   = sub ? ~b : b;
        sum     = a + b_eff + {{(DATA_W-1){1'b0}}, sub};
        ovf_raw = (a[DATA_W-1] == b_eff[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
        lt_s    = $signed(a) < $signed(b);
        lt_u    = a < b;
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import iu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [SH_W-1:0]   shamt,
    input  logic [5:0]        func,
    input  logic              imm_sel,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result,
    output logic              ovf,
    output logic              illegal
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              ovf;
        logic              bad;
    } out_t;

    decode_t           dec;
    out_t              out_d, out_q;
    logic [DATA_W-1:0] b_op, upper_val, sh_out, sum;
    logic [SH_W-1:0]   sh_amt;
    logic              ovf_raw, lt_s, lt_u;

    // Decode: the legal set differs between register and immediate mode.
    always_comb begin
        dec           = '0;
        dec.kind      = K_BAD;
        dec.var_shift = func[2];
        dec.sh_left   = (func[1:0] == 2'b00);
        dec.sh_arith  = (func[1:0] == 2'b11);
        if (imm_sel) begin
            case (func)
                FN_ADD:  begin dec.kind = K_ADD;  dec.trap = 1'b1; dec.ext_sign = 1'b1; end
                FN_ADDU: begin dec.kind = K_ADD;  dec.ext_sign = 1'b1; end
                FN_AND:  dec.kind = K_AND;
                FN_OR:   dec.kind = K_OR;
                FN_XOR:  dec.kind = K_XOR;
                FN_SLT:  begin dec.kind = K_SLT;  dec.ext_sign = 1'b1; end
                FN_SLTU: begin dec.kind = K_SLTU; dec.ext_sign = 1'b1; end
                FN_LUI:  dec.kind = K_LUI;
                default: dec.kind = K_BAD;
            endcase
        end else begin
            case (func)
                FN_ADD:  begin dec.kind = K_ADD; dec.trap = 1'b1; end
                FN_ADDU: dec.kind = K_ADD;
                FN_SUB:  begin dec.kind = K_SUB; dec.trap = 1'b1; end
                FN_SUBU: dec.kind = K_SUB;
                FN_AND:  dec.kind = K_AND;
                FN_OR:   dec.kind = K_OR;
                FN_XOR:  dec.kind = K_XOR;
                FN_NOR:  dec.kind = K_NOR;
                FN_SLT:  dec.kind = K_SLT;
                FN_SLTU: dec.kind = K_SLTU;
                FN_SLL, FN_SRL, FN_SRA,
                FN_SLLV, FN_SRLV, FN_SRAV: dec.kind = K_SHIFT;
                default: dec.kind = K_BAD;
            endcase
        end
    end

    iu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_opsel (
        .rt_val    (op_b),
        .rs_low    (op_a[SH_W-1:0]),
        .shamt     (shamt),
        .imm       (imm),
        .imm_sel   (imm_sel),
        .ext_sign  (dec.ext_sign),
        .var_shift (dec.var_shift),
        .b_op      (b_op),
        .sh_amt    (sh_amt),
        .upper_val (upper_val)
    );

    iu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .din   (op_b),
        .amt   (sh_amt),
        .left  (dec.sh_left),
        .arith (dec.sh_arith),
        .dout  (sh_out)
    );

    iu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a       (op_a),
        .b       (b_op),
        .sub     (dec.kind == K_SUB),
        .sum     (sum),
        .ovf_raw (ovf_raw),
        .lt_s    (lt_s),
        .lt_u    (lt_u)
    );

    // Next-value computation.
    always_comb begin
        out_d = '0;
        case (dec.kind)
            K_ADD, K_SUB: begin
                out_d.res = sum;
                out_d.ovf = dec.trap & ovf_raw;
            end
            K_AND:   out_d.res = op_a & b_op;
            K_OR:    out_d.res = op_a | b_op;
            K_XOR:   out_d.res = op_a ^ b_op;
            K_NOR:   out_d.res = ~(op_a | b_op);
            K_SLT:   out_d.res = {{(DATA_W-1){1'b0}}, lt_s};
            K_SLTU:  out_d.res = {{(DATA_W-1){1'b0}}, lt_u};
            K_SHIFT: out_d.res = sh_out;
            K_LUI:   out_d.res = upper_val;
            default: out_d.bad = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result  = out_q.res;
    assign ovf     = out_q.ovf;
    assign illegal = out_q.bad;

    AST_ILLEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0) && !ovf); // R11
    AST_PLAIN_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (func == FN_ADDU || func == FN_SUBU) |=> !ovf); // R3
    AST_OVF_TRAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(func == FN_ADD || func == FN_SUB) |=> !ovf); // R3
    AST_SLT_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (func == FN_SLT || func == FN_SLTU) |=> (result[DATA_W-1:1] == '0) && !illegal); // R5
    AST_UPPER_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_sel && func == FN_LUI) |=> (result[IMM_W-1:0] == '0) && !ovf && !illegal); // R10

endmodule

// File: tb/int_exec_unit_test.sv
`timescale 1ns/1ps
module int_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [4:0]  shamt = '0;
    logic [5:0]  func = '0;
    logic        imm_sel = 1'b0;
    logic [15:0] imm = '0;
    logic [31:0] result;
    logic        ovf, illegal;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] r;
        logic        o;
        logic        il;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    int_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .shamt(shamt),
        .func(func), .imm_sel(imm_sel), .imm(imm),
        .result(result), .ovf(ovf), .illegal(illegal)
    );

    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input logic [4:0] sa, input logic [5:0] f,
                                   input logic is, input logic [15:0] im);
        exp_t e;
        logic [31:0] sx, zx, d;
        logic [32:0] t;
        e.r = '0; e.o = 1'b0; e.il = 1'b0; e.tag = "";
        sx = {{16{im[15]}}, im};
        zx = {16'h0, im};
        if (is) begin
            case (f)
                6'b100000: begin e.r = a + sx;
                    e.o = (a[31] == sx[31]) && (e.r[31] != a[31]); end
                6'b100001: e.r = a + sx;
                6'b100100: e.r = a & zx;
                6'b100101: e.r = a | zx;
                6'b100110: e.r = a ^ zx;
                6'b101010: e.r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
                6'b101011: e.r = (a < sx) ? 32'd1 : 32'd0;
                6'b001111: e.r = {im, 16'h0};
                default:   e.il = 1'b1;
            endcase
        end else begin
            case (f)
                6'b100000: begin e.r = a + b;
                    e.o = (a[31] == b[31]) && (e.r[31] != a[31]); end
                6'b100001: e.r = a + b;
                6'b100010: begin e.r = a - b;
                    e.o = (a[31] != b[31]) && (e.r[31] != a[31]); end
                6'b100011: e.r = a - b;
                6'b100100: e.r = a & b;
                6'b100101: e.r = a | b;
                6'b100110: e.r = a ^ b;
                6'b100111: e.r = ~(a | b);
                6'b101010: e.r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                6'b101011: e.r = (a < b) ? 32'd1 : 32'd0;
                6'b000000: e.r = b << sa;
                6'b000010: e.r = b >> sa;
                6'b000011: begin d = b; for (int k = 0; k < 32; k++) if (k < sa) d = {b[31], d[31:1]}; e.r = d; end
                6'b000100: e.r = b << a[4:0];
                6'b000110: e.r = b >> a[4:0];
                6'b000111: begin d = b; for (int k = 0; k < 32; k++) if (k < a[4:0]) d = {b[31], d[31:1]}; e.r = d; end
                default:   e.il = 1'b1;
            endcase
        end
        t = '0;
        if (t != 0) e.r = '0;
        return e;
    endfunction

    task automatic drive(input string tag, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sa, input logic [5:0] f,
                         input logic is, input logic [15:0] im);
        exp_t e;
        @(negedge clk);
        op_a = a; op_b = b; shamt = sa; func = f; imm_sel = is; imm = im;
        e = model(a, b, sa, f, is, im);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic expect_val(input string tag, input logic [31:0] r, input logic o,
                              input logic il, input logic [31:0] er, input logic eo,
                              input logic eil);
        checks++;
        if (r !== er || o !== eo || il !== eil) begin
            errors++;
            $display("FAIL %s: got result=%h ovf=%b illegal=%b, expected result=%h ovf=%b illegal=%b",
                     tag, r, o, il, er, eo, eil);
        end
    endtask

    // Monitor: one expected item per cycle, compared just after the registering edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                expect_val(e.tag, result, ovf, illegal, e.r, e.o, e.il);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with non-zero inputs applied
        op_a = 32'hFFFF_FFFF; op_b = 32'h1234_5678; func = 6'b100101;
        repeat (3) @(posedge clk);
        #2;
        expect_val("R1 reset", result, ovf, illegal, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R3 arithmetic at the signed limits
        drive("R2 add", 32'd5, 32'd7, 5'd0, 6'b100000, 1'b0, 16'h0);
        drive("R3 add overflow", 32'h7FFF_FFFF, 32'd1, 5'd0, 6'b100000, 1'b0, 16'h0);
        drive("R3 addu no overflow", 32'h7FFF_FFFF, 32'd1, 5'd0, 6'b100001, 1'b0, 16'h0);
        drive("R3 sub overflow", 32'h8000_0000, 32'd1, 5'd0, 6'b100010, 1'b0, 16'h0);
        drive("R3 subu no overflow", 32'h8000_0000, 32'd1, 5'd0, 6'b100011, 1'b0, 16'h0);
        drive("R2 sub negative", 32'd3, 32'd5, 5'd0, 6'b100010, 1'b0, 16'h0);
        // R4 bitwise
        drive("R4 and", 32'hF0F0_FF00, 32'hFF00_0FF0, 5'd0, 6'b100100, 1'b0, 16'h0);
        drive("R4 or",  32'hF0F0_FF00, 32'hFF00_0FF0, 5'd0, 6'b100101, 1'b0, 16'h0);
        drive("R4 xor", 32'hF0F0_FF00, 32'hFF00_0FF0, 5'd0, 6'b100110, 1'b0, 16'h0);
        drive("R4 nor", 32'hF0F0_FF00, 32'hFF00_0FF0, 5'd0, 6'b100111, 1'b0, 16'h0);
        // R5 compare
        drive("R5 slt signed", 32'hFFFF_FFFF, 32'd1, 5'd0, 6'b101010, 1'b0, 16'h0);
        drive("R5 sltu unsigned", 32'hFFFF_FFFF, 32'd1, 5'd0, 6'b101011, 1'b0, 16'h0);
        drive("R5 slt equal", 32'd9, 32'd9, 5'd0, 6'b101010, 1'b0, 16'h0);
        // R6 / R8 fixed shifts, op_a garbage must not matter
        drive("R6 sll 4", 32'hDEAD_0000, 32'h8000_000F, 5'd4, 6'b000000, 1'b0, 16'h0);
        drive("R8 srl 4 zero fill", 32'h0, 32'h8000_000F, 5'd4, 6'b000010, 1'b0, 16'h0);
        drive("R8 sra 4 sign fill", 32'h0, 32'h8000_000F, 5'd4, 6'b000011, 1'b0, 16'h0);
        drive("R8 sra 31 negative", 32'h0, 32'h8000_0000, 5'd31, 6'b000011, 1'b0, 16'h0);
        drive("R8 sra 31 positive", 32'h0, 32'h7FFF_FFFF, 5'd31, 6'b000011, 1'b0, 16'h0);
        drive("R6 sll 0", 32'h0, 32'hCAFE_BABE, 5'd0, 6'b000000, 1'b0, 16'h0);
        // R7 variable shifts: only op_a[4:0] counts, shamt ignored
        drive("R7 sllv upper ignored", 32'hFFFF_FFE3, 32'h0000_0011, 5'd17, 6'b000100, 1'b0, 16'h0);
        drive("R7 srlv", 32'h0000_0104, 32'hF000_0000, 5'd1, 6'b000110, 1'b0, 16'h0);
        drive("R7 srav", 32'hABCD_EF1F, 32'h8000_0000, 5'd2, 6'b000111, 1'b0, 16'h0);
        // R9 immediates
        drive("R9 addi sign ext", 32'd10, 32'h5555_5555, 5'd0, 6'b100000, 1'b1, 16'hFFFF);
        drive("R3 addi overflow", 32'h7FFF_FFFF, 32'h0, 5'd0, 6'b100000, 1'b1, 16'h0001);
        drive("R3 addiu no overflow", 32'h7FFF_FFFF, 32'h0, 5'd0, 6'b100001, 1'b1, 16'h0001);
        drive("R9 andi zero ext", 32'hFFFF_FFFF, 32'h0, 5'd0, 6'b100100, 1'b1, 16'h8001);
        drive("R9 ori zero ext", 32'h1200_0000, 32'h0, 5'd0, 6'b100101, 1'b1, 16'hF00F);
        drive("R9 xori zero ext", 32'hFFFF_0000, 32'h0, 5'd0, 6'b100110, 1'b1, 16'hFFFF);
        drive("R9 slti sign ext", 32'hFFFF_FFFE, 32'h0, 5'd0, 6'b101010, 1'b1, 16'hFFFF);
        drive("R9 sltiu sign ext", 32'd5, 32'h0, 5'd0, 6'b101011, 1'b1, 16'hFFFF);
        // R10 load upper
        drive("R10 lui", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 6'b001111, 1'b1, 16'hABCD);
        // R11 illegal
        drive("R11 reg illegal 000001", 32'h7FFF_FFFF, 32'd1, 5'd0, 6'b000001, 1'b0, 16'h0);
        drive("R11 imm sub illegal", 32'h8000_0000, 32'd1, 5'd0, 6'b100010, 1'b1, 16'h0001);
        drive("R11 reg lui illegal", 32'h0, 32'h0, 5'd0, 6'b001111, 1'b0, 16'hABCD);
        drive("R11 imm shift illegal", 32'h3, 32'hFF, 5'd3, 6'b000000, 1'b1, 16'h0);
        // Mixed stream over R2..R11
        for (int n = 0; n < 400; n++) begin
            logic [5:0] f;
            f = 6'($urandom_range(0, 63));
            if (n % 2 == 0) f = {1'b1, 1'b0, 4'($urandom_range(0, 11))};
            drive("R2-R11 mixed", $urandom, $urandom, 5'($urandom), f,
                  1'($urandom), 16'($urandom));
        end
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule